// File: doc/BRIEF.md
# Character Display Controller Core

This block models the command processor of a character display module as a host sees it on its byte-wide bus. Each access is a single-cycle strobe with a register-select bit, a read/write bit and a data byte. An access can write a command, read the status byte, or write or read a byte in one of two on-chip RAMs. The two RAMs are an 80-entry display buffer of character codes, arranged as two 40-column lines, and a 64-byte glyph pattern store. One address counter serves both RAMs, and the most recent address-set command decides which RAM it points into.

Each accepted command or data access starts a busy interval whose length depends on the kind of operation. The lengths are given in clock cycles and derived from a clock-frequency parameter. While the interval runs, the block refuses everything except status reads, so the host polls bit 7 of the status byte before it issues the next access. The display, cursor, blink, bus-width, line-count, font and entry-mode settings are kept in registers that drive output pins for the scanning logic.

Top module: `chardisp_ctrl`

## Requirements
- R1: After reset, busy is 0, the address counter is 0x00 and points into the display RAM, and busOut is 0x00. Every mode output is 0 except incMode, which is 1. Every display RAM entry holds FILL_CODE (default 0x20).
- R2: A strobe with regSel=0 and readMode=1 puts {busy, address counter[6:0]} on busOut in the following cycle. This works even while busy, and it starts no busy interval.
- R3: A data strobe (regSel=1) writes busIn to the selected RAM at the counter (readMode=0), or loads that RAM byte onto busOut in the next cycle (readMode=1). After either one the counter moves one step, up when incMode=1 and down when incMode=0.
- R4: A command byte (regSel=0, readMode=0) is decoded by its highest set bit. Bit 7 sets a display address, bit 6 a pattern address, bit 5 is function set, bit 4 is shift, bit 3 is display control, bit 2 is entry mode, bit 1 is home and bit 0 is clear. The byte 0x00 has no effect and starts no busy interval.
- R5: While busy is 1, every strobe other than a status read is ignored: the RAMs, the counter and the mode outputs stay as they were.
- R6: Busy rises in the cycle after an accepted strobe and stays high for exactly LONG cycles after clear or home, SHORT cycles after any other command, and DATA cycles after a data access. With CLK_HZ=1 MHz these are 1530, 39 and 43.
- R7: A pattern-address command (01aaaaaa) loads the counter with 0aaaaaa and selects the pattern RAM. A display-address command (1laaaaaa) loads line bit l and column aaaaaa, and selects the display RAM.
- R8: Display addresses stay inside 0x00–0x27 and 0x40–0x67. Stepping up from 0x27 gives 0x40 and from 0x67 gives 0x00; stepping down reverses both. A loaded column above 0x27 is reduced by 40.
- R9: Pattern RAM addresses wrap modulo 64 in both directions, and status bit 6 reads 0 while the pattern RAM is selected.
- R10: Clear (0x01) writes FILL_CODE into all 80 display entries, sets the counter to 0 and selects the display RAM. Home (0000001x) does the same without touching any RAM byte.
- R11: A shift command (0001 s r xx) with s=0 moves the counter one step, up when r=1 and down when r=0, under the R8/R9 wrap rules. With s=1 the counter does not change.
- R12: Display control (00001dcb) loads dispOn=d, cursorOn=c, blinkOn=b. Function set (001wnf xx) loads busWide=w, twoLines=n, tallFont=f. Entry mode (000001is) loads incMode=i, shiftOnEntry=s.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| accStrobe | input | 1 | One-cycle access request |
| regSel | input | 1 | 0: command/status, 1: RAM data |
| readMode | input | 1 | 1: read, 0: write |
| busIn | input | 8 | Command or data byte from host |
| busOut | output | 8 | Read result, held until the next read |
| busy | output | 1 | Execution in progress |
| dispOn | output | 1 | Display enable setting |
| cursorOn | output | 1 | Cursor enable setting |
| blinkOn | output | 1 | Cursor blink setting |
| busWide | output | 1 | 8-bit bus width setting |
| twoLines | output | 1 | Two-line mode setting |
| tallFont | output | 1 | Tall font setting |
| incMode | output | 1 | Counter steps up after data access |
| shiftOnEntry | output | 1 | Display shift on entry setting |

## Verification
A fault in the address counter, or in its wrap at line and RAM boundaries, shows up on the next status read one cycle after the strobe, and on the next data read as the wrong byte. A busy counter loaded with the wrong length changes the number of cycles busy stays high, so the bench counts that interval exactly for each class of operation. A failure to block accesses during busy leaves a changed mode pin, counter value or RAM byte, and the bench reads it back once the interval ends.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  // strobes from control to datapath, at most one access kind per cycle
  typedef struct packed {
    logic doClear;
    logic doHome;
    logic loadDd;
    logic loadCg;
    logic step;
    logic stepUp;
    logic wrRam;
    logic rdRam;
    logic rdStatus;
  } cdStrobe_t;
endpackage

// File: rtl/chardisp_ctl.sv
module chardisp_ctl
  import chardisp_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      accStrobe,
  input  logic      regSel,
  input  logic      readMode,
  input  logic [7:0] busIn,
  output cdStrobe_t cs,
  output logic      busy,
  output logic [7:0] modeBits
);
  localparam int KHZ       = CLK_HZ / 1000;
  localparam int LONG_CYC  = KHZ * 153 / 100;
  localparam int SHORT_CYC = KHZ * 39 / 1000;
  localparam int DATA_CYC  = KHZ * 43 / 1000;
  localparam int CW        = $clog2(LONG_CYC + 1);

  logic [CW-1:0] busyCnt, loadVal;
  logic doLoad, setFunc, setDisp, setEntry;
  logic dispOn, cursorOn, blinkOn, busWide, twoLines, tallFont, incMode, shiftOnEntry;

  assign busy = (busyCnt != '0);
  assign modeBits = {dispOn, cursorOn, blinkOn, busWide, twoLines, tallFont, incMode, shiftOnEntry};

  always_comb begin
    cs = '0;
    doLoad = 1'b0;
    loadVal = '0;
    setFunc = 1'b0;
    setDisp = 1'b0;
    setEntry = 1'b0;
    cs.rdStatus = accStrobe && !regSel && readMode;
    if (accStrobe && !busy) begin
      if (regSel) begin
        cs.wrRam  = !readMode;
        cs.rdRam  = readMode;
        cs.step   = 1'b1;
        cs.stepUp = incMode;
        doLoad    = 1'b1;
        loadVal   = CW'(DATA_CYC);
      end else if (!readMode) begin
        doLoad  = 1'b1;
        loadVal = CW'(SHORT_CYC);
        casez (busIn)
          8'b1???????: cs.loadDd = 1'b1;
          8'b01??????: cs.loadCg = 1'b1;
          8'b001?????: setFunc = 1'b1;
          8'b0001????: begin
            cs.step   = !busIn[3];
            cs.stepUp = busIn[2];
          end
          8'b00001???: setDisp = 1'b1;
          8'b000001??: setEntry = 1'b1;
          8'b0000001?: begin
            cs.doHome = 1'b1;
            loadVal   = CW'(LONG_CYC);
          end
          8'b00000001: begin
            cs.doClear = 1'b1;
            loadVal    = CW'(LONG_CYC);
          end
          default: doLoad = 1'b0;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busyCnt <= '0;
      {dispOn, cursorOn, blinkOn} <= '0;
      {busWide, twoLines, tallFont} <= '0;
      incMode <= 1'b1;
      shiftOnEntry <= 1'b0;
    end else begin
      if (doLoad) busyCnt <= loadVal;
      else if (busy) busyCnt <= busyCnt - CW'(1);
      if (setDisp) {dispOn, cursorOn, blinkOn} <= busIn[2:0];
      if (setFunc) {busWide, twoLines, tallFont} <= busIn[4:2];
      if (setEntry) {incMode, shiftOnEntry} <= busIn[1:0];
    end
  end

  // R5: settings frozen while a command executes
  assert_mode_frozen_R5: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(modeBits));
  // R6: an accepted access starts the busy interval
  assert_busy_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && !busy && (regSel || (!readMode && busIn != 8'h00))) |=> busy);
  // R6: busy never starts without a host strobe
  assert_busy_cause_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(accStrobe));
  // R2: status reads never start busy
  assert_status_free_R2: assert property (@(posedge clk) disable iff (!rstN)
    (accStrobe && !regSel && readMode && !busy) |=> !busy);
endmodule

// File: rtl/chardisp_dp.sv
module chardisp_dp
  import chardisp_pkg::*;
#(
  parameter int DD_COLS = 40,
  parameter logic [7:0] FILL_CODE = 8'h20
) (
  input  logic      clk,
  input  logic      rstN,
  input  cdStrobe_t cs,
  input  logic [7:0] busIn,
  input  logic      busyIn,
  output logic [7:0] busOut
);
  localparam int DD_DEPTH = 2 * DD_COLS;
  localparam int CG_DEPTH = 64;
  localparam logic [5:0] LAST_COL = 6'(DD_COLS - 1);

  logic [7:0] ddMem [DD_DEPTH];
  logic [7:0] cgMem [CG_DEPTH];
  logic [6:0] ac;
  logic       ddSel;
  logic [6:0] ddIdx;
  logic [5:0] loadCol;

  assign ddIdx = ac[6] ? (7'(ac[5:0]) + 7'(DD_COLS)) : 7'(ac[5:0]);
  // columns past the line end fold back by one line length
  assign loadCol = (busIn[5:0] > LAST_COL) ? (busIn[5:0] - 6'(DD_COLS)) : busIn[5:0];

  function automatic logic [6:0] stepAddr(input logic [6:0] a, input logic up, input logic dd);
    if (!dd) return {1'b0, up ? a[5:0] + 6'd1 : a[5:0] - 6'd1};
    if (up) return (a[5:0] == LAST_COL) ? {~a[6], 6'd0} : a + 7'd1;
    return (a[5:0] == 6'd0) ? {~a[6], LAST_COL} : a - 7'd1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ac     <= '0;
      ddSel  <= 1'b1;
      busOut <= '0;
      for (int i = 0; i < DD_DEPTH; i++) ddMem[i] <= FILL_CODE;
      for (int i = 0; i < CG_DEPTH; i++) cgMem[i] <= '0;
    end else begin
      if (cs.doClear) begin
        for (int i = 0; i < DD_DEPTH; i++) ddMem[i] <= FILL_CODE;
      end
      if (cs.doClear || cs.doHome) begin
        ac    <= '0;
        ddSel <= 1'b1;
      end else if (cs.loadDd) begin
        ac    <= {busIn[6], loadCol};
        ddSel <= 1'b1;
      end else if (cs.loadCg) begin
        ac    <= {1'b0, busIn[5:0]};
        ddSel <= 1'b0;
      end else if (cs.step) begin
        ac <= stepAddr(ac, cs.stepUp, ddSel);
      end
      if (cs.wrRam) begin
        if (ddSel) ddMem[ddIdx] <= busIn;
        else cgMem[ac[5:0]] <= busIn;
      end
      if (cs.rdRam) busOut <= ddSel ? ddMem[ddIdx] : cgMem[ac[5:0]];
      else if (cs.rdStatus) busOut <= {busyIn, ac};
    end
  end

  // R5: counter holds while a command executes
  assert_ac_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    busyIn |=> $stable(ac));
  // R8: display address inside the two valid windows
  assert_dd_range_R8: assert property (@(posedge clk) disable iff (!rstN)
    ddSel |-> (ac[5:0] <= LAST_COL));
  // R9: pattern address keeps bit 6 clear
  assert_cg_range_R9: assert property (@(posedge clk) disable iff (!rstN)
    !ddSel |-> !ac[6]);
  // R10: clear and home land on display address zero
  assert_clear_home_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cs.doClear || cs.doHome) |=> (ac == 7'd0 && ddSel));
endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl
  import chardisp_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter int DD_COLS = 40,
  parameter logic [7:0] FILL_CODE = 8'h20
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       accStrobe,
  input  logic       regSel,
  input  logic       readMode,
  input  logic [7:0] busIn,
  output logic [7:0] busOut,
  output logic       busy,
  output logic       dispOn,
  output logic       cursorOn,
  output logic       blinkOn,
  output logic       busWide,
  output logic       twoLines,
  output logic       tallFont,
  output logic       incMode,
  output logic       shiftOnEntry
);
  cdStrobe_t cs;
  logic [7:0] modeBits;

  chardisp_ctl #(.CLK_HZ(CLK_HZ)) u_ctl (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .regSel(regSel),
    .readMode(readMode), .busIn(busIn), .cs(cs), .busy(busy), .modeBits(modeBits)
  );

  chardisp_dp #(.DD_COLS(DD_COLS), .FILL_CODE(FILL_CODE)) u_dp (
    .clk(clk), .rstN(rstN), .cs(cs), .busIn(busIn), .busyIn(busy), .busOut(busOut)
  );

  assign {dispOn, cursorOn, blinkOn, busWide, twoLines, tallFont, incMode, shiftOnEntry} = modeBits;
endmodule

// File: tb/chardisp_ctrl_bench.sv
module chardisp_ctrl_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic accStrobe = 1'b0, regSel = 1'b0, readMode = 1'b0;
  logic [7:0] busIn = '0;
  logic [7:0] busOut;
  logic busy, dispOn, cursorOn, blinkOn, busWide, twoLines, tallFont, incMode, shiftOnEntry;
  int nChk = 0, nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  chardisp_ctrl #(.CLK_HZ(1_000_000)) u_chardisp_ctrl (
    .clk(clk), .rstN(rstN), .accStrobe(accStrobe), .regSel(regSel), .readMode(readMode),
    .busIn(busIn), .busOut(busOut), .busy(busy), .dispOn(dispOn), .cursorOn(cursorOn),
    .blinkOn(blinkOn), .busWide(busWide), .twoLines(twoLines), .tallFont(tallFont),
    .incMode(incMode), .shiftOnEntry(shiftOnEntry)
  );

  // {rs, rw, data[7:0], expect[7:0], chk, req[3:0]}
  localparam int NV = 49;
  localparam logic [22:0] VEC [NV] = '{
    {2'b00, 8'h38, 8'h00, 1'b0, 4'd12}, // R12 function set
    {2'b00, 8'h06, 8'h00, 1'b0, 4'd3},  // R3 increment
    {2'b00, 8'h80, 8'h00, 1'b0, 4'd7},  // R7
    {2'b10, 8'h41, 8'h00, 1'b0, 4'd3},
    {2'b10, 8'h42, 8'h00, 1'b0, 4'd3},
    {2'b01, 8'h00, 8'h02, 1'b1, 4'd3},  // R3 counter advanced twice
    {2'b00, 8'h80, 8'h00, 1'b0, 4'd7},
    {2'b11, 8'h00, 8'h41, 1'b1, 4'd3},
    {2'b11, 8'h00, 8'h42, 1'b1, 4'd3},
    {2'b00, 8'hA7, 8'h00, 1'b0, 4'd8},  // R8 to 0x27
    {2'b10, 8'h5A, 8'h00, 1'b0, 4'd8},
    {2'b01, 8'h00, 8'h40, 1'b1, 4'd8},  // R8 0x27 -> 0x40
    {2'b00, 8'h04, 8'h00, 1'b0, 4'd3},  // decrement
    {2'b10, 8'h33, 8'h00, 1'b0, 4'd8},
    {2'b01, 8'h00, 8'h27, 1'b1, 4'd8},  // R8 0x40 -> 0x27
    {2'b11, 8'h00, 8'h5A, 1'b1, 4'd8},
    {2'b01, 8'h00, 8'h26, 1'b1, 4'd3},  // R3 read decrements
    {2'b00, 8'h40, 8'h00, 1'b0, 4'd7},  // R7 pattern RAM
    {2'b10, 8'h1F, 8'h00, 1'b0, 4'd9},
    {2'b01, 8'h00, 8'h3F, 1'b1, 4'd9},  // R9 0 -> 63
    {2'b00, 8'h06, 8'h00, 1'b0, 4'd3},
    {2'b10, 8'hAA, 8'h00, 1'b0, 4'd9},
    {2'b01, 8'h00, 8'h00, 1'b1, 4'd9},  // R9 63 -> 0
    {2'b11, 8'h00, 8'h1F, 1'b1, 4'd7},
    {2'b00, 8'h7F, 8'h00, 1'b0, 4'd7},
    {2'b11, 8'h00, 8'hAA, 1'b1, 4'd9},
    {2'b00, 8'hB2, 8'h00, 1'b0, 4'd8},  // R8 column 50 folds to 10
    {2'b01, 8'h00, 8'h0A, 1'b1, 4'd8},
    {2'b00, 8'h01, 8'h00, 1'b0, 4'd10}, // R10 clear
    {2'b01, 8'h00, 8'h00, 1'b1, 4'd10},
    {2'b00, 8'hC0, 8'h00, 1'b0, 4'd7},
    {2'b11, 8'h00, 8'h20, 1'b1, 4'd10}, // R10 0x40 cleared
    {2'b00, 8'h85, 8'h00, 1'b0, 4'd7},
    {2'b00, 8'h02, 8'h00, 1'b0, 4'd10}, // R10 home
    {2'b01, 8'h00, 8'h00, 1'b1, 4'd10},
    {2'b00, 8'h14, 8'h00, 1'b0, 4'd11}, // R11 cursor right
    {2'b01, 8'h00, 8'h01, 1'b1, 4'd11},
    {2'b00, 8'h10, 8'h00, 1'b0, 4'd11},
    {2'b00, 8'h10, 8'h00, 1'b0, 4'd11},
    {2'b01, 8'h00, 8'h67, 1'b1, 4'd11}, // R11 left past 0x00
    {2'b00, 8'h18, 8'h00, 1'b0, 4'd11}, // display shift
    {2'b01, 8'h00, 8'h67, 1'b1, 4'd11},
    {2'b00, 8'h00, 8'h00, 1'b0, 4'd4},  // R4 null byte
    {2'b01, 8'h00, 8'h67, 1'b1, 4'd4},
    {2'b10, 8'h77, 8'h00, 1'b0, 4'd8},
    {2'b00, 8'h02, 8'h00, 1'b0, 4'd10},
    {2'b11, 8'h00, 8'h20, 1'b1, 4'd10},
    {2'b00, 8'hE7, 8'h00, 1'b0, 4'd7},
    {2'b11, 8'h00, 8'h77, 1'b1, 4'd10}  // R10 home kept RAM
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic access(input logic rs, input logic rw, input logic [7:0] d);
    accStrobe = 1'b1; regSel = rs; readMode = rw; busIn = d;
    @(negedge clk);
    accStrobe = 1'b0;
  endtask

  task automatic waitIdle();
    while (busy) @(negedge clk);
  endtask

  task automatic busyLen(output int n);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
  endtask

  task automatic finishRun();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 busy", 16'(busy), 16'h0);
    check("R1 busOut", 16'(busOut), 16'h0);
    check("R1 modes", 16'({dispOn, cursorOn, blinkOn, busWide, twoLines, tallFont, incMode, shiftOnEntry}), 16'h02);
    access(1'b0, 1'b1, 8'h00);
    check("R1 counter", 16'(busOut), 16'h00);
    access(1'b1, 1'b1, 8'h00); waitIdle();
    check("R1 fill", 16'(busOut), 16'h20);

    for (int i = 0; i < NV; i++) begin
      access(VEC[i][22], VEC[i][21], VEC[i][20:13]);
      waitIdle();
      if (VEC[i][4]) check($sformatf("R%0d vec %0d", VEC[i][3:0], i), 16'(busOut), 16'(VEC[i][12:5]));
    end
    check("R12 function bits", 16'({busWide, twoLines, tallFont}), 16'b110);

    // R12 display control and entry mode
    access(1'b0, 1'b0, 8'h0D); busyLen(n);
    check("R6 short", 16'(n), 16'd39);
    check("R12 display bits", 16'({dispOn, cursorOn, blinkOn}), 16'b101);
    access(1'b0, 1'b0, 8'h07); waitIdle();
    check("R12 entry bits", 16'({incMode, shiftOnEntry}), 16'b11);
    access(1'b0, 1'b0, 8'h06); waitIdle();

    // R6 data timing
    access(1'b1, 1'b0, 8'h11); busyLen(n);
    check("R6 data", 16'(n), 16'd43);

    // R2 status during busy, R5 ignored accesses
    access(1'b0, 1'b0, 8'h01);
    access(1'b0, 1'b1, 8'h00);
    check("R2 busy status", 16'(busOut), 16'h80);
    access(1'b0, 1'b0, 8'h0F);
    access(1'b0, 1'b0, 8'h85);
    access(1'b1, 1'b0, 8'h99);
    busyLen(n);
    check("R6 long", 16'(n), 16'd1526);
    check("R5 display bits", 16'({dispOn, cursorOn, blinkOn}), 16'b101);
    access(1'b0, 1'b1, 8'h00);
    check("R5 counter", 16'(busOut), 16'h00);
    check("R2 no busy", 16'(busy), 16'h0);
    access(1'b1, 1'b1, 8'h00); waitIdle();
    check("R5 ram", 16'(busOut), 16'h20);

    // R6 exact long interval from idle
    access(1'b0, 1'b0, 8'h02); busyLen(n);
    check("R6 home", 16'(n), 16'd1530);
    finishRun();
  end
endmodule